// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. It runs entirely in the bit-clock domain. On every rising bit-clock edge it samples the serial data line and the frame (left/right) clock. A change in the frame clock from one rising edge to the next marks the start of a new half-frame. Each half-frame carries one channel word, sent most significant bit first in two's complement form.

A format pin selects one of two framings. With the pin low, the word is MSB-justified: its first bit is on the same rising edge at which the frame-clock change is seen, and the left channel is the half-frame with the frame clock high. With the pin high, the framing is I2S: the first bit comes one bit clock later, and the left channel is the half-frame with the frame clock low.

When a half-frame ends, the finished word for that channel is presented on its 24-bit output with a one-cycle valid strobe. Sources that send 16 or 20 bits are accepted when the sender fills the unused low bits with zeros.

The outputs follow a valid-only stream rule. The serial source cannot be paused, so there is no ready input and no back-pressure. A consumer must take each word in the cycle its strobe is high. The data stays unchanged until that channel's next strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high, and after it, until the first strobe, both data outputs are zero and both strobes are low.
- R2: With the format pin low (MSB-justified), the half-frame with the frame clock high is left and the one with it low is right. The bit sampled on the rising edge at which the frame-clock change is first seen is the word's MSB (bit 23).
- R3: With the format pin high (I2S), the half-frame with the frame clock low is left and the one with it high is right. The MSB is the bit sampled one rising edge after the edge at which the change is seen. The bit sampled at the next frame-clock change still belongs to the word that is ending, so a 24-bit word fits in a 24-cycle half-frame.
- R4: Bits that arrive after the 24th bit of a half-frame are ignored.
- R5: When a half-frame carries fewer than 24 bits, the missing low bits of the word are zero. A 16-bit or 20-bit source sent with zeroed low bits comes out unchanged.
- R6: A channel's strobe is high for exactly one cycle. That cycle is the one after the rising edge at which the next frame-clock change is seen. The data output holds its value between strobes.
- R7: The bits received before the first frame-clock change after reset, and any partial half-frame there, produce no strobe. The first complete half-frame is the first one delivered.
- R8: The left and right strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; all sampling and state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Frame (left/right) clock |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| fmt_i2s_i | input | 1 | Framing select: 0 = MSB-justified, 1 = I2S |
| left_data_o | output | 24 | Last completed left word |
| left_valid_o | output | 1 | One-cycle strobe for a new left word |
| right_data_o | output | 24 | Last completed right word |
| right_valid_o | output | 1 | One-cycle strobe for a new right word |

## Verification
Inputs are driven on the falling bit-clock edge. The frame-clock change driven at falling edge t is taken in at rising edge t+1, and the finished word for the previous channel is visible at the falling edge after that. That is one register stage in total. The bench stamps each drive and each observed strobe with a rising-edge count, and requires every strobe to land exactly one count after the edge that closed its half-frame. It also compares each captured word and channel against a model. That model applies the framing offset, the 24-bit limit and the short-frame zero fill to the words it sent.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CH_LEFT  = 0;
  localparam int CH_RIGHT = 1;
  localparam int NUM_CH   = 2;

  // counter must reach WORD_W + 1 (saturation point past the last slot)
  function automatic int cnt_width(input int word_w);
    return $clog2(word_w + 2);
  endfunction
endpackage

// File: rtl/sar_frame_track.sv
module sar_frame_track #(
  parameter int W     = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_i,
  input  logic             fmt_i2s_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] last_cyc_o,
  output logic             left_now_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(W + 1);

  logic             frame_q;
  logic             seen_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_o     = frame_i ^ frame_q;
  assign cyc_o      = edge_o ? '0 : cnt_q;
  assign last_cyc_o = cnt_q;
  assign left_now_o = fmt_i2s_i ? ~frame_i : frame_i;
  assign armed_o    = seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_i;
      seen_q  <= seen_q | edge_o;
      cnt_q   <= (cyc_o == LIM) ? LIM : cyc_o + 1'b1;
    end
  end

  // R4
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= LIM);
endmodule

// File: rtl/sar_bit_steer.sv
module sar_bit_steer #(
  parameter int W     = 24,
  parameter int CNT_W = 5
) (
  input  logic             edge_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] last_cyc_i,
  input  logic             left_now_i,
  input  logic             fmt_i2s_i,
  input  logic             armed_i,
  output logic [1:0]       clr_o,
  output logic [1:0]       pub_o,
  output logic [1:0]       cap_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(W);

  logic cur, prv;

  always_comb begin
    cur   = left_now_i ? 1'b0 : 1'b1;
    prv   = ~cur;
    clr_o = '0;
    pub_o = '0;
    cap_o = '0;
    idx_o = '0;
    if (edge_i) begin
      clr_o[cur] = 1'b1;
      pub_o[prv] = armed_i;
      if (fmt_i2s_i) begin
        // trailing slot of the word that is closing
        idx_o      = last_cyc_i - 1'b1;
        cap_o[prv] = armed_i && (last_cyc_i != '0) && (last_cyc_i <= W_C);
      end else begin
        idx_o      = '0;
        cap_o[cur] = 1'b1;
      end
    end else if (fmt_i2s_i) begin
      idx_o      = cyc_i - 1'b1;
      cap_o[cur] = (cyc_i != '0) && (cyc_i <= W_C);
    end else begin
      idx_o      = cyc_i;
      cap_o[cur] = cyc_i < W_C;
    end
  end
endmodule

// File: rtl/sar_word_collector.sv
module sar_word_collector #(
  parameter int W     = 24,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic             pub_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             sd_i,
  output logic [W-1:0]     data_o,
  output logic             valid_o
);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] acc_q, data_q, bitv;
  logic         valid_q;

  assign bitv    = (cap_i && sd_i) ? (TOP >> idx_i) : '0;
  assign data_o  = data_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      acc_q   <= clr_i ? bitv : (acc_q | bitv);
      valid_q <= pub_i;
      if (pub_i) data_q <= acc_q | bitv;
    end
  end

  // R6
  valid_once_chk: assert property (@(posedge clk) disable iff (rst) valid_q |=> !valid_q);
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst) !valid_o |-> $stable(data_o));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int W = 24
) (
  input  logic         bclk_i,
  input  logic         rst_i,
  input  logic         frame_i,
  input  logic         sdata_i,
  input  logic         fmt_i2s_i,
  output logic [W-1:0] left_data_o,
  output logic         left_valid_o,
  output logic [W-1:0] right_data_o,
  output logic         right_valid_o
);
  import sar_pkg::*;
  localparam int CNT_W = cnt_width(W);

  logic             edge_s, left_now, armed;
  logic [CNT_W-1:0] cyc, last_cyc, idx;
  logic [1:0]       clr, pub, cap;
  logic [W-1:0]     ch_data  [NUM_CH];
  logic             ch_valid [NUM_CH];

  sar_frame_track #(.W(W), .CNT_W(CNT_W)) u_track (
    .clk(bclk_i), .rst(rst_i), .frame_i(frame_i), .fmt_i2s_i(fmt_i2s_i),
    .edge_o(edge_s), .cyc_o(cyc), .last_cyc_o(last_cyc),
    .left_now_o(left_now), .armed_o(armed)
  );

  sar_bit_steer #(.W(W), .CNT_W(CNT_W)) u_steer (
    .edge_i(edge_s), .cyc_i(cyc), .last_cyc_i(last_cyc), .left_now_i(left_now),
    .fmt_i2s_i(fmt_i2s_i), .armed_i(armed),
    .clr_o(clr), .pub_o(pub), .cap_o(cap), .idx_o(idx)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sar_word_collector #(.W(W), .CNT_W(CNT_W)) u_col (
      .clk(bclk_i), .rst(rst_i), .clr_i(clr[g]), .cap_i(cap[g]), .pub_i(pub[g]),
      .idx_i(idx), .sd_i(sdata_i), .data_o(ch_data[g]), .valid_o(ch_valid[g])
    );
  end

  assign left_data_o   = ch_data[CH_LEFT];
  assign left_valid_o  = ch_valid[CH_LEFT];
  assign right_data_o  = ch_data[CH_RIGHT];
  assign right_valid_o = ch_valid[CH_RIGHT];

  // R8
  chan_excl_chk: assert property (@(posedge bclk_i) disable iff (rst_i)
    !(left_valid_o && right_valid_o));
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame = 1'b0, sdata = 1'b0, fmt = 1'b0;
  logic [23:0] ldata, rdata;
  logic        lvalid, rvalid;

  int n_chk = 0, n_fail = 0, tick = 0;
  int obs_n = 0, overlap = 0, dbl = 0;
  int obs_ch [64];
  int obs_tk [64];
  logic [23:0] obs_d [64];
  logic pl = 1'b0, pr = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  serial_audio_rx u_serial_audio_rx (
    .bclk_i(clk), .rst_i(rst), .frame_i(frame), .sdata_i(sdata), .fmt_i2s_i(fmt),
    .left_data_o(ldata), .left_valid_o(lvalid),
    .right_data_o(rdata), .right_valid_o(rvalid)
  );

  always #2 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  always @(negedge clk) begin
    if (lvalid && rvalid) overlap++;
    if ((lvalid && pl) || (rvalid && pr)) dbl++;
    pl = lvalid; pr = rvalid;
    if (lvalid && obs_n < 64) begin obs_ch[obs_n] = 0; obs_d[obs_n] = ldata; obs_tk[obs_n] = tick; obs_n++; end
    if (rvalid && obs_n < 64) begin obs_ch[obs_n] = 1; obs_d[obs_n] = rdata; obs_tk[obs_n] = tick; obs_n++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] top_mask(input int k);
    if (k >= 24) return 24'hFF_FFFF;
    return ~((24'h1 << (24 - k)) - 24'h1);
  endfunction

  task automatic do_reset(input bit f);
    @(negedge clk);
    rst = 1'b1; frame = 1'b0; sdata = 1'b0; fmt = f;
    repeat (2) @(negedge clk);
    obs_n = 0; overlap = 0; dbl = 0;
    rst = 1'b0;
  endtask

  // R1: reset state
  task automatic test_reset();
    do_reset(1'b0);
    chk(ldata == 24'h0, "R1", "left data", ldata, 0);
    chk(rdata == 24'h0, "R1", "right data", rdata, 0);
    chk(!lvalid && !rvalid, "R1", "strobes", {lvalid, rvalid}, 0);
  endtask

  // generic stream scenario; tag names the requirements it targets
  task automatic run_stream(input bit f, input int n, input int nh,
                            input int srcbits, input string tag);
    logic [23:0] src [16];
    int etk [16];
    int p, last_l;
    logic b, lvl;
    do_reset(f);
    // R7: junk before the first frame edge
    repeat (5) begin @(negedge clk); sdata = 1'b1; frame = 1'b0; end
    for (int h = 0; h < nh; h++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      src[h] = seed[30:7] & top_mask(srcbits);
    end
    for (int h = 0; h < nh; h++) begin
      lvl = (h % 2 == 0);
      for (int c = 0; c < n; c++) begin
        if (f && c == 0) begin
          p = n - 1;
          b = (h == 0 || p >= 24) ? 1'b1 : src[h-1][23-p];
        end else begin
          p = f ? c - 1 : c;
          b = (p < 24) ? src[h][23-p] : 1'b1;
        end
        @(negedge clk);
        frame = lvl; sdata = b;
        if (c == 0) etk[h] = tick;
      end
    end
    repeat (2) @(negedge clk);
    chk(obs_n == nh - 1, {tag, " R7"}, "word count", obs_n, nh - 1);
    chk(overlap == 0, "R8", "both strobes", overlap, 0);
    chk(dbl == 0, "R6", "strobe longer than one cycle", dbl, 0);
    last_l = -1;
    for (int i = 0; i < nh - 1 && i < obs_n; i++) begin
      logic [23:0] e;
      int ech;
      e   = src[i] & top_mask(n < 24 ? n : 24);
      ech = f ? ((i % 2 == 0) ? 1 : 0) : ((i % 2 == 0) ? 0 : 1);
      if (ech == 0) last_l = i;
      chk(obs_d[i] == e, tag, "word", obs_d[i], e);
      chk(obs_ch[i] == ech, {tag, " R2 R3"}, "channel", obs_ch[i], ech);
      chk(obs_tk[i] == etk[i+1] + 1, "R6", "strobe cycle", obs_tk[i], etk[i+1] + 1);
    end
    if (last_l >= 0)
      chk(ldata == (src[last_l] & top_mask(n < 24 ? n : 24)), "R6", "left hold",
          ldata, src[last_l] & top_mask(n < 24 ? n : 24));
  endtask

  task automatic test_msb_basic();  run_stream(1'b0, 32, 6, 24, "R2"); endtask
  task automatic test_i2s_tight();  run_stream(1'b1, 24, 6, 24, "R3"); endtask
  task automatic test_i2s_16bit();  run_stream(1'b1, 32, 6, 16, "R5 R3"); endtask
  task automatic test_msb_long();   run_stream(1'b0, 40, 5, 24, "R4"); endtask
  task automatic test_msb_short();  run_stream(1'b0, 20, 5, 24, "R5"); endtask
  task automatic test_i2s_long20(); run_stream(1'b1, 64, 5, 20, "R4 R5"); endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    test_reset();
    test_msb_basic();
    test_i2s_tight();
    test_i2s_16bit();
    test_msb_long();
    test_msb_short();
    test_i2s_long20();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule